// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The block moves received frames into memory buffers that software hands over through a circular ring of descriptors. Each descriptor is one 64-bit word in an external descriptor RAM. It holds a status/control half-word, a length half-word and a 32-bit buffer address. An empty flag in the status passes ownership between software and hardware. The engine only fills a descriptor that is marked empty. When the frame is complete it clears the flag, so software can see that the buffer now holds a frame.

Software starts the engine with a one-cycle kick, which stands for a write to the descriptor-active register. The first kick after reset points the engine at the ring base index. Before each frame arrives, the engine fetches the current descriptor and keeps it armed. Bytes from the receive stream are written one by one to the buffer. The engine then writes back the length and error bits, and steps to the next descriptor. The descriptor that carries the wrap flag closes the ring, and the step after it returns to the base.

The byte stream has no back-pressure. A frame that starts while no descriptor is armed is discarded as a whole and reported as an overrun. This happens before the first kick, while a fetch is in flight, and after a stall. The engine stalls when it finds a descriptor that software has not freed. It then issues no more fetches until the next kick, which re-reads the same index.

Top module: `rxbd_engine`

## Requirements
- R1: After reset the engine is inactive: it reads no descriptor, writes neither descriptors nor buffers, and holds `frame_done` and `overrun` low until the first kick.
- R2: The descriptor word is laid out as follows: status in bits 63:48, length in 47:32, buffer address in 31:0. The empty flag is status bit 15. The first kick after reset issues a one-cycle descriptor read at `ring_base`, and the data is returned on the next cycle.
- R3: In an accepted frame, the byte at position k (counted from the beat carrying `rx_sof`) is written to buffer address + k, one byte per valid beat.
- R4: The write-back keeps the buffer address and stores the number of bytes received, CRC included, as the length. In the status it clears bit 15, keeps bits 14:6 and replaces bits 5:0 with the error code.
- R5: Error bit 0 is set when `rx_err` was high on any beat of the frame. Error bit 1 is set when the recorded length is below `MIN_FRAME`.
- R6: A frame longer than `BUF_SIZE` has no byte written past offset `BUF_SIZE`-1. It is recorded with length `BUF_SIZE` and error bit 5. A frame of exactly `BUF_SIZE` bytes is not flagged.
- R7: After a write-back, the next fetch reads the following index. If the written descriptor has status bit 13 (wrap) set, the next fetch reads `ring_base` instead.
- R8: A fetched descriptor with bit 15 clear stalls the engine. No further descriptor reads happen until a kick, and the kick re-reads the same index.
- R9: A frame whose `rx_sof` beat arrives while no descriptor is armed is dropped: none of its bytes is written. `overrun` pulses for one cycle on the cycle after that beat.
- R10: `frame_done` is high for exactly the one cycle after each descriptor write-back cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | One-cycle pulse that (re)activates descriptor polling |
| ring_base | input | DIDX_W | Index of the first descriptor of the ring |
| desc_rd_en | output | 1 | Descriptor read request, data expected next cycle |
| desc_wr_en | output | 1 | Descriptor write-back strobe |
| desc_addr | output | DIDX_W | Descriptor index for read or write |
| desc_rdata | input | 64 | Descriptor word returned one cycle after the read |
| desc_wdata | output | 64 | Descriptor word written back |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Receive error seen on this beat |
| rx_data | input | 8 | Receive byte |
| buf_wr_en | output | 1 | Buffer byte write strobe |
| buf_wr_addr | output | 32 | Buffer byte address |
| buf_wr_data | output | 8 | Buffer byte data |
| frame_done | output | 1 | One-cycle pulse after each write-back |
| overrun | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The bench builds the engine with `DIDX_W` = 3, `BUF_SIZE` = 40 and `MIN_FRAME` = 16, and uses a four-descriptor ring at indices 2 to 5. A small buffer size means a 45-byte frame reaches truncation and a 40-byte frame sits exactly on the limit, both within a few dozen cycles. The small minimum puts short and normal frames side by side. With a ring of four, a single run fills every descriptor, wraps back to a base that is not index 0, runs into a descriptor that software has not freed, and then resumes after a kick.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  // Descriptor word: status | length | buffer address
  localparam int DESC_W        = 64;
  localparam int LEN_W         = 16;
  localparam int ERR_W         = 6;

  // Status bit positions that software and hardware both decode
  localparam int ST_EMPTY_BIT  = 15;
  localparam int ST_WRAP_BIT   = 13;

  // Error code positions inside the low status bits
  localparam int ERR_RX_BIT    = 0;
  localparam int ERR_SHORT_BIT = 1;
  localparam int ERR_TRUNC_BIT = 5;

  // Status bits replaced at write-back: ownership flag and error code
  localparam logic [15:0] ST_WB_MASK = 16'h803F;

  typedef struct packed {
    logic [15:0] status;
    logic [15:0] len;
    logic [31:0] addr;
  } rx_desc_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_CHECK = 3'd2,
    S_READY = 3'd3,
    S_RECV  = 3'd4,
    S_WB    = 3'd5
  } rx_state_e;

endpackage

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr #(
  parameter int DIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              advance,
  input  logic              wrap,
  input  logic [DIDX_W-1:0] base,
  output logic [DIDX_W-1:0] ptr
);

  logic              started_q;
  logic              started_d;
  logic [DIDX_W-1:0] ptr_q;
  logic [DIDX_W-1:0] ptr_d;
  logic              ptr_en;

  always_comb begin
    started_d = started_q;
    ptr_d     = ptr_q;
    if (kick && !started_q) begin
      started_d = 1'b1;
      ptr_d     = base;
    end else if (advance) begin
      ptr_d = wrap ? base : ptr_q + 1'b1;
    end
  end

  assign ptr_en = (kick && !started_q) || advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      ptr_q     <= '0;
    end else if (ptr_en) begin
      started_q <= started_d;
      ptr_q     <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/rxbd_frame_acc.sv
module rxbd_frame_acc
  import rxbd_pkg::*;
#(
  parameter int BUF_SIZE  = 1520,
  parameter int MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             beat,
  input  logic             err_in,
  output logic             wr_ok,
  output logic [LEN_W-1:0] wr_off,
  output logic [LEN_W-1:0] len,
  output logic [ERR_W-1:0] errs
);

  localparam logic [LEN_W-1:0] CAP  = LEN_W'(BUF_SIZE);
  localparam logic [LEN_W-1:0] MINL = LEN_W'(MIN_FRAME);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic             err_q;
  logic             err_d;
  logic             trunc_q;
  logic             trunc_d;
  logic             at_cap;
  logic             acc_en;

  assign at_cap = (cnt_q == CAP);
  assign acc_en = start || beat;

  always_comb begin
    cnt_d   = cnt_q;
    err_d   = err_q;
    trunc_d = trunc_q;
    if (start) begin
      cnt_d   = LEN_W'(1);
      err_d   = err_in;
      trunc_d = 1'b0;
    end else if (beat) begin
      err_d = err_q || err_in;
      if (at_cap) trunc_d = 1'b1;
      else        cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      err_q   <= 1'b0;
      trunc_q <= 1'b0;
    end else if (acc_en) begin
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      trunc_q <= trunc_d;
    end
  end

  assign wr_ok  = start || (beat && !at_cap);
  assign wr_off = start ? '0 : cnt_q;
  assign len    = cnt_q;

  always_comb begin
    errs                = '0;
    errs[ERR_RX_BIT]    = err_q;
    errs[ERR_SHORT_BIT] = (cnt_q < MINL);
    errs[ERR_TRUNC_BIT] = trunc_q;
  end

endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
  import rxbd_pkg::*;
#(
  parameter int DIDX_W    = 4,
  parameter int BUF_SIZE  = 1520,
  parameter int MIN_FRAME = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [DIDX_W-1:0] ring_base,
  output logic              desc_rd_en,
  output logic              desc_wr_en,
  output logic [DIDX_W-1:0] desc_addr,
  input  logic [63:0]       desc_rdata,
  output logic [63:0]       desc_wdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [7:0]        rx_data,
  output logic              buf_wr_en,
  output logic [31:0]       buf_wr_addr,
  output logic [7:0]        buf_wr_data,
  output logic              frame_done,
  output logic              overrun
);

  rx_state_e        st_q;
  rx_state_e        st_d;
  rx_desc_t         fetched;
  rx_desc_t         desc_q;
  rx_desc_t         wb;
  logic             cap_en;
  logic             start;
  logic             beat;
  logic             drop_sof;
  logic             done_q;
  logic             ovr_q;
  logic             wr_ok;
  logic [LEN_W-1:0] wr_off;
  logic [LEN_W-1:0] frame_len;
  logic [ERR_W-1:0] frame_errs;
  logic [DIDX_W-1:0] ptr;

  assign fetched  = rx_desc_t'(desc_rdata);
  assign start    = (st_q == S_READY) && rx_valid && rx_sof;
  assign beat     = (st_q == S_RECV) && rx_valid;
  assign drop_sof = rx_valid && rx_sof && (st_q != S_READY) && (st_q != S_RECV);
  assign cap_en   = (st_q == S_CHECK) && fetched.status[ST_EMPTY_BIT];

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (kick) st_d = S_FETCH;
      S_FETCH: st_d = S_CHECK;
      S_CHECK: begin
        if (fetched.status[ST_EMPTY_BIT]) st_d = S_READY;
        else if (kick)                    st_d = S_FETCH;
        else                              st_d = S_IDLE;
      end
      S_READY: if (start) st_d = rx_eof ? S_WB : S_RECV;
      S_RECV:  if (rx_valid && rx_eof) st_d = S_WB;
      S_WB:    st_d = S_FETCH;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      desc_q <= '0;
    else if (cap_en) desc_q <= fetched;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= (st_q == S_WB);
      ovr_q  <= drop_sof;
    end
  end

  rxbd_ring_ptr #(.DIDX_W(DIDX_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick    (kick),
    .advance (st_q == S_WB),
    .wrap    (desc_q.status[ST_WRAP_BIT]),
    .base    (ring_base),
    .ptr     (ptr)
  );

  rxbd_frame_acc #(.BUF_SIZE(BUF_SIZE), .MIN_FRAME(MIN_FRAME)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .beat   (beat),
    .err_in (rx_err),
    .wr_ok  (wr_ok),
    .wr_off (wr_off),
    .len    (frame_len),
    .errs   (frame_errs)
  );

  // write-back word: hand ownership back, record length and errors
  always_comb begin
    wb        = desc_q;
    wb.status = (desc_q.status & ~ST_WB_MASK) | {{(16-ERR_W){1'b0}}, frame_errs};
    wb.len    = frame_len;
  end

  assign desc_rd_en  = (st_q == S_FETCH);
  assign desc_wr_en  = (st_q == S_WB);
  assign desc_addr   = ptr;
  assign desc_wdata  = wb;
  assign buf_wr_en   = wr_ok;
  assign buf_wr_addr = desc_q.addr + {{(32-LEN_W){1'b0}}, wr_off};
  assign buf_wr_data = rx_data;
  assign frame_done  = done_q;
  assign overrun     = ovr_q;

endmodule

// File: rtl/rxbd_engine_chk.sv
module rxbd_engine_chk #(
  parameter int DIDX_W    = 4,
  parameter int BUF_SIZE  = 1520,
  parameter int MIN_FRAME = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIDX_W-1:0] ring_base,
  input logic              desc_rd_en,
  input logic              desc_wr_en,
  input logic [DIDX_W-1:0] desc_addr,
  input logic [63:0]       desc_wdata,
  input logic              rx_valid,
  input logic              rx_sof,
  input logic              buf_wr_en,
  input logic              frame_done,
  input logic              overrun
);

  localparam logic [15:0] CAP = 16'(BUF_SIZE);

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_rd_en |=> !desc_rd_en); // R2

  AST_BUF_WR_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> rx_valid); // R3

  AST_WB_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> !desc_wdata[63]); // R4

  AST_WB_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |-> (desc_wdata[47:32] <= CAP)); // R6

  AST_TRUNC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr_en && desc_wdata[53]) |-> (desc_wdata[47:32] == CAP)); // R6

  AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr_en && desc_wdata[61]) |=> (desc_rd_en && desc_addr == $past(ring_base))); // R7

  AST_NEXT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr_en && !desc_wdata[61]) |=> (desc_rd_en && desc_addr == DIDX_W'($past(desc_addr) + 1'b1))); // R7

  AST_OVR_AFTER_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(rx_valid && rx_sof)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_en |=> frame_done); // R10

  AST_DONE_ONLY_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(desc_wr_en)); // R10

endmodule

bind rxbd_engine rxbd_engine_chk #(
  .DIDX_W    (DIDX_W),
  .BUF_SIZE  (BUF_SIZE),
  .MIN_FRAME (MIN_FRAME)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ring_base  (ring_base),
  .desc_rd_en (desc_rd_en),
  .desc_wr_en (desc_wr_en),
  .desc_addr  (desc_addr),
  .desc_wdata (desc_wdata),
  .rx_valid   (rx_valid),
  .rx_sof     (rx_sof),
  .buf_wr_en  (buf_wr_en),
  .frame_done (frame_done),
  .overrun    (overrun)
);

// File: tb/rxbd_engine_bench.sv
module rxbd_engine_bench;

  localparam int DW   = 3;
  localparam int BS   = 40;
  localparam int MF   = 16;
  localparam logic [DW-1:0] BASE = 3'd2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          kick;
  logic [DW-1:0] ring_base;
  logic          desc_rd_en, desc_wr_en;
  logic [DW-1:0] desc_addr;
  logic [63:0]   desc_rdata, desc_wdata;
  logic          rx_valid, rx_sof, rx_eof, rx_err;
  logic [7:0]    rx_data;
  logic          buf_wr_en;
  logic [31:0]   buf_wr_addr;
  logic [7:0]    buf_wr_data;
  logic          frame_done, overrun;

  always #4 clk = ~clk;

  rxbd_engine #(.DIDX_W(DW), .BUF_SIZE(BS), .MIN_FRAME(MF)) u_rxbd_engine (
    .clk(clk), .rst_n(rst_n), .kick(kick), .ring_base(ring_base),
    .desc_rd_en(desc_rd_en), .desc_wr_en(desc_wr_en), .desc_addr(desc_addr),
    .desc_rdata(desc_rdata), .desc_wdata(desc_wdata),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .rx_data(rx_data), .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr),
    .buf_wr_data(buf_wr_data), .frame_done(frame_done), .overrun(overrun)
  );

  // descriptor RAM and buffer RAM models
  logic [63:0]   dmem [0:7];
  logic [7:0]    bmem [0:511];
  logic          sw_we;
  logic [DW-1:0] sw_idx;
  logic [63:0]   sw_val;

  always @(posedge clk) begin
    if (desc_rd_en) desc_rdata <= dmem[desc_addr];
    if (desc_wr_en) dmem[desc_addr] <= desc_wdata;
    if (sw_we)      dmem[sw_idx] <= sw_val;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) bmem[i] <= 8'hEE;
    end else if (buf_wr_en) begin
      bmem[buf_wr_addr[8:0]] <= buf_wr_data;
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // activity counters sampled at the clock edge
  int rd_cnt = 0, wr_cnt = 0, bw_cnt = 0, ovr_cnt = 0;
  logic [DW-1:0] last_rd;
  always @(posedge clk) begin
    if (rst_n) begin
      if (desc_rd_en) begin rd_cnt++; last_rd = desc_addr; end
      if (desc_wr_en) wr_cnt++;
      if (buf_wr_en)  bw_cnt++;
      if (overrun)    ovr_cnt++;
    end
  end

  // scoreboard
  typedef struct packed {
    logic [DW-1:0] idx;
    logic [15:0]   st;
    logic [15:0]   len;
    logic [31:0]   addr;
    logic [7:0]    seed;
    logic          trunc;
  } exp_t;

  exp_t q[$];
  logic [DW-1:0] exp_ptr;
  logic          done_pending = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_pending) check(frame_done === 1'b1, "R10", "frame_done after write-back", 64'(frame_done), 64'd1);
      done_pending = desc_wr_en;
      if (desc_wr_en) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected write-back", 64'(desc_addr), 64'd0);
        end else begin
          exp_t e;
          int bad;
          e = q.pop_front();
          check(desc_addr == e.idx, "R7", "write-back index", 64'(desc_addr), 64'(e.idx));
          check(desc_wdata[63:48] == e.st, "R4 R5 R6", "status", 64'(desc_wdata[63:48]), 64'(e.st));
          check(desc_wdata[47:32] == e.len, "R4 R6", "length", 64'(desc_wdata[47:32]), 64'(e.len));
          check(desc_wdata[31:0] == e.addr, "R4", "buffer address", 64'(desc_wdata[31:0]), 64'(e.addr));
          bad = 0;
          for (int k = 0; k < int'(e.len); k++)
            if (bmem[9'(e.addr + 32'(k))] !== 8'(e.seed + 8'(k))) bad++;
          check(bad == 0, "R3", "buffer byte mismatches", 64'(bad), 64'd0);
          if (e.trunc)
            check(bmem[9'(e.addr + 32'(BS))] === 8'hEE, "R6", "byte past limit",
                  64'(bmem[9'(e.addr + 32'(BS))]), 64'hEE);
        end
      end
    end
  end

  task automatic sw_write(input logic [DW-1:0] idx, input logic [63:0] val);
    @(negedge clk);
    sw_we = 1'b1; sw_idx = idx; sw_val = val;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic do_kick();
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input logic with_err, input logic taken,
                            input logic [7:0] seed);
    if (taken) begin
      exp_t e;
      int stored;
      logic [5:0] errs;
      stored = (n > BS) ? BS : n;
      errs = {(n > BS), 3'b000, (stored < MF), with_err};
      e.idx   = exp_ptr;
      e.addr  = dmem[exp_ptr][31:0];
      e.st    = (dmem[exp_ptr][63:48] & 16'h7FC0) | {10'b0, errs};
      e.len   = 16'(stored);
      e.seed  = seed;
      e.trunc = (n > BS);
      q.push_back(e);
      exp_ptr = dmem[exp_ptr][61] ? BASE : exp_ptr + 1'b1;
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (k == 0);
      rx_eof   = (k == n - 1);
      rx_err   = with_err && (k == n / 2);
      rx_data  = seed + 8'(k);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ovr0, bw0, rd0;
    rst_n = 1'b0; kick = 1'b0; ring_base = BASE; sw_we = 1'b0; sw_idx = '0; sw_val = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0; rx_data = '0;
    exp_ptr = BASE;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) sw_write(3'(i), 64'd0);
    sw_write(3'd2, {16'h8404, 16'd0, 32'h080});
    sw_write(3'd3, {16'h8404, 16'd0, 32'h0C0});
    sw_write(3'd4, {16'h8404, 16'd0, 32'h100});
    sw_write(3'd5, {16'hA404, 16'd0, 32'h140});

    // R1: quiet before the first kick
    check(rd_cnt == 0 && wr_cnt == 0 && bw_cnt == 0, "R1", "activity before kick",
          64'(rd_cnt + wr_cnt + bw_cnt), 64'd0);
    check(frame_done == 1'b0 && overrun == 1'b0, "R1", "pulses before kick",
          64'({frame_done, overrun}), 64'd0);

    // R9: frame before the first kick is dropped
    ovr0 = ovr_cnt; bw0 = bw_cnt;
    send_frame(20, 1'b0, 1'b0, 8'h10);
    check(ovr_cnt == ovr0 + 1, "R9", "overrun pulses", 64'(ovr_cnt - ovr0), 64'd1);
    check(bw_cnt == bw0, "R9", "bytes written for dropped frame", 64'(bw_cnt - bw0), 64'd0);
    check(rd_cnt == 0, "R1", "reads before kick", 64'(rd_cnt), 64'd0);

    // R2: first kick fetches at ring base
    do_kick();
    check(rd_cnt == 1, "R2", "fetch count after kick", 64'(rd_cnt), 64'd1);
    check(last_rd == BASE, "R2", "first fetch index", 64'(last_rd), 64'(BASE));

    send_frame(24, 1'b0, 1'b1, 8'h20);   // R3 R4 good frame
    send_frame(30, 1'b1, 1'b1, 8'h40);   // R5 receive error
    send_frame(10, 1'b0, 1'b1, 8'h60);   // R5 short frame
    send_frame(45, 1'b0, 1'b1, 8'h80);   // R6 truncated, R7 wrap descriptor

    // R8: ring wrapped onto a descriptor still owned by software
    check(last_rd == BASE, "R7", "fetch after wrap", 64'(last_rd), 64'(BASE));
    rd0 = rd_cnt;
    repeat (20) @(negedge clk);
    check(rd_cnt == rd0, "R8", "fetches while stalled", 64'(rd_cnt - rd0), 64'd0);

    ovr0 = ovr_cnt; bw0 = bw_cnt;
    send_frame(18, 1'b0, 1'b0, 8'hA0);
    check(ovr_cnt == ovr0 + 1, "R9", "overrun while stalled", 64'(ovr_cnt - ovr0), 64'd1);
    check(bw_cnt == bw0, "R9", "bytes written while stalled", 64'(bw_cnt - bw0), 64'd0);
    check(dmem[2][63:48] == 16'h0400, "R8", "stalled descriptor untouched",
          64'(dmem[2][63:48]), 64'h0400);

    // software frees two buffers and re-arms
    sw_write(3'd2, {16'h8000, 16'd0, 32'h080});
    sw_write(3'd3, {16'h8001, 16'd0, 32'h0C0});
    rd0 = rd_cnt;
    do_kick();
    check(rd_cnt == rd0 + 1 && last_rd == BASE, "R8", "re-armed fetch index",
          64'(last_rd), 64'(BASE));

    send_frame(40, 1'b0, 1'b1, 8'hB0);   // R6 exactly at limit
    send_frame(1, 1'b0, 1'b1, 8'hC0);    // R5 single-byte frame

    repeat (10) @(negedge clk);
    check(q.size() == 0, "R4", "write-backs outstanding", 64'(q.size()), 64'd0);
    check(wr_cnt == 6, "R4", "write-back count", 64'(wr_cnt), 64'd6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule